// File: doc/BRIEF.md
# DMA Transfer Sequencer with Bus Handshake

This block is the transfer engine of a four-channel DMA controller. Each channel has a request input from its peripheral. The engine ignores requests from masked channels and, when several remain, picks the lowest-numbered one. It then asks the CPU for the system bus with a hold request. Only after the CPU answers with a hold acknowledge does it touch the bus. While it owns the bus it drives the chosen channel's acknowledge line and runs byte cycles. Each byte cycle puts out the current address and pulses a read strobe and then a write strobe: memory-read with I/O-write, or I/O-read with memory-write.

Per-channel settings arrive as static inputs from a separate register block:
- service mode;
- direction;
- address step sign;
- auto-reload;
- base address and base count, with a load pulse and a mask write port.

The engine keeps the current address, current count and mask bit of every channel. After each byte it steps the address and count. On the final byte it raises end-of-process. Three service modes decide whether the bus is kept between bytes: demand, block and single.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the hold request is low, all read and write strobes are low, every acknowledge line sits at its inactive level, and all four mask bits read 1.
- R2: The hold request is raised only from idle, and only when the grant input is low. No acknowledge line or strobe becomes active until the grant input has been seen high.
- R3: Among channels whose request is active and whose mask bit is 0, the lowest-numbered channel is served. A masked channel's request has no effect, and at most one acknowledge line is active at a time.
- R4: A byte cycle lasts four clocks when ready is high. In clock 1 the acknowledge and address are driven. In clocks 2 to 4 the read strobe is on. In clocks 3 and 4 the write strobe is also on. Clock 4 repeats while ready is low. Direction bit 0 selects memory-read with I/O-write; direction bit 1 selects I/O-read with memory-write.
- R5: After each byte the current count drops by one, and the current address rises by one (address-step bit 0) or falls by one (address-step bit 1). A transfer programmed with count N moves N+1 bytes. End-of-process is high during the fourth clock of the byte that started with count 0.
- R6: In demand mode (mode code 00) the engine starts another byte immediately while the channel's request is still active. It releases the bus when the request is inactive at the end of a byte.
- R7: In block mode (mode code 10) a request is needed only to start. The engine then keeps the bus until the terminal-count byte.
- R8: In single mode (mode code 01) the hold request drops after every byte for at least one clock. The channel is served again only through a new handshake.
- R9: At terminal count, a channel with auto-reload set copies its base address and count back into the current ones and keeps its mask bit at 0. A channel without auto-reload gets its mask bit set to 1.
- R10: With the request-polarity input at 1, requests are active low. With the acknowledge-polarity input at 1, acknowledge lines are driven active low.
- R11: While the enable input is 0 the engine does not raise the hold request. Requests pending while disabled are served once it returns to 1.
- R12: The hold request stays high throughout bus ownership, from the handshake to the end of the last byte of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Global enable for starting service |
| dreq_low_i | input | 1 | 1: request inputs are active low |
| dack_low_i | input | 1 | 1: acknowledge outputs are active low |
| mode_i | input | NCH*2 | Per-channel service mode: 00 demand, 01 single, 10 block |
| dir_i | input | NCH | Per-channel direction: 0 memory to I/O, 1 I/O to memory |
| addr_dec_i | input | NCH | Per-channel address step: 0 increment, 1 decrement |
| autoinit_i | input | NCH | Per-channel auto-reload at terminal count |
| base_addr_i | input | NCH*AW | Per-channel base address |
| base_count_i | input | NCH*CW | Per-channel base count (bytes minus one) |
| load_i | input | NCH | Copies base address and count into the current ones |
| mask_wr_i | input | 1 | Writes mask_data_i into the mask bits |
| mask_data_i | input | NCH | Mask values for a mask write |
| dreq_i | input | NCH | Peripheral request lines |
| hlda_i | input | 1 | Bus grant from the CPU |
| ready_i | input | 1 | Low stretches the last clock of a byte cycle |
| hrq_o | output | 1 | Bus hold request to the CPU |
| dack_o | output | NCH | Peripheral acknowledge lines |
| addr_o | output | AW | Transfer address (zero when not in a byte cycle) |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| eop_o | output | 1 | End of process, during the terminal-count byte |
| mask_o | output | NCH | Current mask bits |

## Verification
The hardest situation to reach from the ports is where the engine and the CPU disagree about bus ownership. That happens when single mode re-requests while a slow grant is still high from the previous byte. The bench's CPU model therefore has a programmable grant lag, which makes the engine wait in idle for the grant to fall before it asks again. A second corner is an auto-reload wrap that falls inside a run stretched by ready. To reach it, the bench toggles ready on a fixed pattern during a single-mode run whose count is smaller than the number of bytes it lets through, so the address must jump back to its base mid-stream.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_C1,
    ST_C2,
    ST_C3,
    ST_C4
  } xfer_state_e;

  typedef enum logic [1:0] {
    SVC_DEMAND = 2'b00,
    SVC_SINGLE = 2'b01,
    SVC_BLOCK  = 2'b10,
    SVC_RSVD   = 2'b11
  } svc_mode_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int N  = 4,
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N*AW-1:0] base_addr_i,
  input  logic [N*CW-1:0] base_count_i,
  input  logic [N-1:0]    load_i,
  input  logic [N-1:0]    autoinit_i,
  input  logic [N-1:0]    addr_dec_i,
  input  logic            mask_wr_i,
  input  logic [N-1:0]    mask_data_i,
  input  logic            step_i,
  input  logic [IW-1:0]   sel_i,
  output logic [AW-1:0]   cur_addr_o,
  output logic            last_o,
  output logic [N-1:0]    mask_o
);
  logic [AW-1:0] addr_arr [N];
  logic [CW-1:0] cnt_arr  [N];

  for (genvar g = 0; g < N; g++) begin : g_chan
    logic [AW-1:0] addr_q;
    logic [CW-1:0] cnt_q;
    logic          mask_q;
    logic          hit, tc;

    assign hit = step_i && (sel_i == IW'(g));
    assign tc  = hit && (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q <= '0;
        cnt_q  <= '0;
      end else if (load_i[g]) begin
        addr_q <= base_addr_i[g*AW +: AW];
        cnt_q  <= base_count_i[g*CW +: CW];
      end else if (tc && autoinit_i[g]) begin
        addr_q <= base_addr_i[g*AW +: AW];
        cnt_q  <= base_count_i[g*CW +: CW];
      end else if (hit) begin
        addr_q <= addr_dec_i[g] ? addr_q - AW'(1) : addr_q + AW'(1);
        cnt_q  <= cnt_q - CW'(1);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  mask_q <= 1'b1;
      else if (mask_wr_i)           mask_q <= mask_data_i[g];
      else if (tc && !autoinit_i[g]) mask_q <= 1'b1;
    end

    assign addr_arr[g] = addr_q;
    assign cnt_arr[g]  = cnt_q;
    assign mask_o[g]   = mask_q;
  end

  assign cur_addr_o = addr_arr[sel_i];
  assign last_o     = (cnt_arr[sel_i] == '0);
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_xfer_pkg::*;
#(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic          hlda_i,
  input  logic          ready_i,
  input  logic          pend_any_i,
  input  logic [IW-1:0] pend_idx_i,
  input  logic          last_i,
  input  logic [1:0]    mode_sel_i,
  input  logic          dreq_sel_i,
  output xfer_state_e   state_o,
  output logic [IW-1:0] sel_o,
  output logic          step_o
);
  xfer_state_e state_q, state_d;
  logic [IW-1:0] sel_q;
  logic          start;

  assign start  = (state_q == ST_IDLE) && enable_i && !hlda_i && pend_any_i;
  assign step_o = (state_q == ST_C4) && ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_REQ;
      ST_REQ:  if (hlda_i) state_d = ST_C1;
      ST_C1:   state_d = ST_C2;
      ST_C2:   state_d = ST_C3;
      ST_C3:   state_d = ST_C4;
      ST_C4: begin
        if (ready_i) begin
          if (last_i) state_d = ST_IDLE;
          else begin
            unique case (svc_mode_e'(mode_sel_i))
              SVC_DEMAND: state_d = dreq_sel_i ? ST_C1 : ST_IDLE;
              SVC_BLOCK:  state_d = ST_C1;
              default:    state_d = ST_IDLE;  // single: release between bytes
            endcase
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) sel_q <= pend_idx_i;
    end
  end

  assign state_o = state_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              dreq_low_i,
  input  logic              dack_low_i,
  input  logic [NCH*2-1:0]  mode_i,
  input  logic [NCH-1:0]    dir_i,
  input  logic [NCH-1:0]    addr_dec_i,
  input  logic [NCH-1:0]    autoinit_i,
  input  logic [NCH*AW-1:0] base_addr_i,
  input  logic [NCH*CW-1:0] base_count_i,
  input  logic [NCH-1:0]    load_i,
  input  logic              mask_wr_i,
  input  logic [NCH-1:0]    mask_data_i,
  input  logic [NCH-1:0]    dreq_i,
  input  logic              hlda_i,
  input  logic              ready_i,
  output logic              hrq_o,
  output logic [NCH-1:0]    dack_o,
  output logic [AW-1:0]     addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              io_rd_o,
  output logic              io_wr_o,
  output logic              eop_o,
  output logic [NCH-1:0]    mask_o
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] dreq_act, pend;
  logic           pend_any, last, step;
  logic [IW-1:0]  pend_idx, sel;
  logic [AW-1:0]  cur_addr;
  xfer_state_e    state;
  logic           active, rd_on, wr_on, dir_sel;
  logic [NCH-1:0] dack_raw;

  assign dreq_act = dreq_i ^ {NCH{dreq_low_i}};
  assign pend     = dreq_act & ~mask_o;

  dma_prio_pick #(.N(NCH)) u_pick (
    .req_i (pend),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );

  dma_xfer_fsm #(.N(NCH)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enable_i   (enable_i),
    .hlda_i     (hlda_i),
    .ready_i    (ready_i),
    .pend_any_i (pend_any),
    .pend_idx_i (pend_idx),
    .last_i     (last),
    .mode_sel_i (mode_i[sel*2 +: 2]),
    .dreq_sel_i (dreq_act[sel]),
    .state_o    (state),
    .sel_o      (sel),
    .step_o     (step)
  );

  dma_chan_regs #(.N(NCH), .AW(AW), .CW(CW)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_addr_i  (base_addr_i),
    .base_count_i (base_count_i),
    .load_i       (load_i),
    .autoinit_i   (autoinit_i),
    .addr_dec_i   (addr_dec_i),
    .mask_wr_i    (mask_wr_i),
    .mask_data_i  (mask_data_i),
    .step_i       (step),
    .sel_i        (sel),
    .cur_addr_o   (cur_addr),
    .last_o       (last),
    .mask_o       (mask_o)
  );

  assign active  = (state == ST_C1) || (state == ST_C2) || (state == ST_C3) || (state == ST_C4);
  assign rd_on   = (state == ST_C2) || (state == ST_C3) || (state == ST_C4);
  assign wr_on   = (state == ST_C3) || (state == ST_C4);
  assign dir_sel = dir_i[sel];

  assign dack_raw = active ? (NCH'(1) << sel) : '0;
  assign dack_o   = dack_raw ^ {NCH{dack_low_i}};
  assign hrq_o    = (state != ST_IDLE);
  assign addr_o   = active ? cur_addr : '0;
  assign mem_rd_o = rd_on & ~dir_sel;
  assign io_wr_o  = wr_on & ~dir_sel;
  assign io_rd_o  = rd_on & dir_sel;
  assign mem_wr_o = wr_on & dir_sel;
  assign eop_o    = (state == ST_C4) && last;
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           enable_i,
  input logic           dack_low_i,
  input logic           hlda_i,
  input logic           ready_i,
  input logic           hrq_o,
  input logic [NCH-1:0] dack_o,
  input logic [AW-1:0]  addr_o,
  input logic           mem_rd_o,
  input logic           mem_wr_o,
  input logic           io_rd_o,
  input logic           io_wr_o,
  input logic           eop_o
);
  logic [NCH-1:0] dack_raw;
  logic           rd_any, wr_any;

  assign dack_raw = dack_o ^ {NCH{dack_low_i}};
  assign rd_any   = mem_rd_o | io_rd_o;
  assign wr_any   = mem_wr_o | io_wr_o;

  assert_hrq_from_free_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hrq_o) |-> $past(!hlda_i));

  assert_dack_after_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|dack_raw) |-> $past(hlda_i));

  assert_one_dack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_raw));

  assert_rw_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o) && !(io_rd_o && io_wr_o));

  assert_strobe_with_dack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any || wr_any) |-> (|dack_raw));

  assert_wait_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && !ready_i) |=> (wr_any && $stable(addr_o)));

  assert_eop_in_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> wr_any);

  assert_disabled_stays_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !hrq_o) |=> !hrq_o);

  assert_bus_kept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dack_raw) |-> hrq_o);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .dack_low_i (dack_low_i),
  .hlda_i     (hlda_i),
  .ready_i    (ready_i),
  .hrq_o      (hrq_o),
  .dack_o     (dack_o),
  .addr_o     (addr_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .io_rd_o    (io_rd_o),
  .io_wr_o    (io_wr_o),
  .eop_o      (eop_o)
);

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;
  localparam int NCH = 4, AW = 16, CW = 16;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_ni = 1'b0;
  logic enable_i = 1'b1, dreq_low_i = 1'b0, dack_low_i = 1'b0;
  logic [NCH*2-1:0]  mode_i = '0;
  logic [NCH-1:0]    dir_i = '0, addr_dec_i = '0, autoinit_i = '0, load_i = '0;
  logic [NCH*AW-1:0] base_addr_i = '0;
  logic [NCH*CW-1:0] base_count_i = '0;
  logic              mask_wr_i = 1'b0;
  logic [NCH-1:0]    mask_data_i = '0, dreq_i = '0;
  logic              hlda_i, ready_i = 1'b1;
  logic              hrq_o, mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, eop_o;
  logic [NCH-1:0]    dack_o, mask_o;
  logic [AW-1:0]     addr_o;

  dma_xfer_engine #(.NCH(NCH), .AW(AW), .CW(CW)) u_dma_xfer_engine (
    .clk_i, .rst_ni, .enable_i, .dreq_low_i, .dack_low_i, .mode_i, .dir_i,
    .addr_dec_i, .autoinit_i, .base_addr_i, .base_count_i, .load_i,
    .mask_wr_i, .mask_data_i, .dreq_i, .hlda_i, .ready_i, .hrq_o, .dack_o,
    .addr_o, .mem_rd_o, .mem_wr_o, .io_rd_o, .io_wr_o, .eop_o, .mask_o
  );

  int checks = 0, errors = 0, cyc = 0;
  int bytes = 0, hrq_falls = 0, lag = 1;
  bit prev_wr = 0, prev_hrq = 0, arm = 0;
  logic [NCH-1:0] first_dack = '0;
  logic [7:0] hist;

  // behavioural reference: phase 0 idle, 1 waiting grant, 2..5 byte clocks
  int ph = 0, msel = 0;
  logic [15:0] maddr [4];
  logic [15:0] mcnt [4];
  logic [3:0]  mmask;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmp(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(posedge clk_i or negedge rst_ni) begin : model
    logic [3:0] act;
    int nxt, s;
    bit lastb;
    if (!rst_ni) begin
      ph = 0; msel = 0; mmask = '1;
      for (int i = 0; i < 4; i++) begin maddr[i] = '0; mcnt[i] = '0; end
    end else begin
      act = dreq_i ^ {4{dreq_low_i}};
      nxt = ph;
      if (ph == 0) begin
        if (enable_i && !hlda_i && |(act & ~mmask)) begin
          s = 0;
          for (int i = 3; i >= 0; i--) if (act[i] && !mmask[i]) s = i;
          msel = s; nxt = 1;
        end
      end else if (ph == 1) begin
        if (hlda_i) nxt = 2;
      end else if (ph < 5) begin
        nxt = ph + 1;
      end else if (ready_i) begin
        lastb = (mcnt[msel] == 0);
        if (lastb && autoinit_i[msel]) begin
          maddr[msel] = base_addr_i[msel*16 +: 16];
          mcnt[msel]  = base_count_i[msel*16 +: 16];
        end else begin
          maddr[msel] = addr_dec_i[msel] ? maddr[msel] - 16'd1 : maddr[msel] + 16'd1;
          mcnt[msel]  = mcnt[msel] - 16'd1;
          if (lastb) mmask[msel] = 1'b1;
        end
        if (lastb) nxt = 0;
        else case (mode_i[msel*2 +: 2])
          2'b00:   nxt = act[msel] ? 2 : 0;
          2'b10:   nxt = 2;
          default: nxt = 0;
        endcase
      end
      for (int i = 0; i < 4; i++) if (load_i[i]) begin
        maddr[i] = base_addr_i[i*16 +: 16];
        mcnt[i]  = base_count_i[i*16 +: 16];
      end
      if (mask_wr_i) mmask = mask_data_i;
      ph = nxt;
    end
  end

  always @(negedge clk_i) begin : mon
    logic [3:0] edack;
    logic [15:0] eaddr;
    bit erd, ewr, ed, wr_now;
    if (rst_ni) begin
      erd   = (ph >= 3);
      ewr   = (ph >= 4);
      ed    = dir_i[msel];
      edack = ((ph >= 2) ? 4'(1 << msel) : 4'd0) ^ {4{dack_low_i}};
      eaddr = (ph >= 2) ? maddr[msel] : 16'd0;
      cmp("R12 hrq", int'(hrq_o), int'(ph != 0));
      cmp("R3 dack", int'(dack_o), int'(edack));
      cmp("R4 mem_rd", int'(mem_rd_o), int'(erd && !ed));
      cmp("R4 io_wr", int'(io_wr_o), int'(ewr && !ed));
      cmp("R4 io_rd", int'(io_rd_o), int'(erd && ed));
      cmp("R4 mem_wr", int'(mem_wr_o), int'(ewr && ed));
      cmp("R5 addr", int'(addr_o), int'(eaddr));
      cmp("R5 eop", int'(eop_o), int'(ph == 5 && mcnt[msel] == 0));
      cmp("R9 mask", int'(mask_o), int'(mmask));
      wr_now = mem_wr_o | io_wr_o;
      if (wr_now && !prev_wr) bytes++;
      if (!hrq_o && prev_hrq) hrq_falls++;
      if (arm && (mem_rd_o || io_rd_o)) begin first_dack = dack_o; arm = 0; end
      prev_wr = wr_now;
      prev_hrq = hrq_o;
    end
    if (!rst_ni) begin
      hist <= '0;
      hlda_i <= 1'b0;
    end else begin
      hist <= {hist[6:0], hrq_o};
      hlda_i <= (lag <= 1) ? hrq_o : hist[lag-2];
    end
  end

  task automatic tick();
    @(negedge clk_i);
    #1;
  endtask

  task automatic run(input int n);
    repeat (n) tick();
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int i = 0; i < 2000 && quiet < 3; i++) begin
      tick();
      if (!hrq_o && !hlda_i) quiet++; else quiet = 0;
    end
  endtask

  task automatic wait_bytes(input int n);
    for (int i = 0; i < 2000 && bytes < n; i++) tick();
  endtask

  task automatic setup(input int ch, input logic [1:0] md, input bit dr, input bit dec,
                       input bit ai, input logic [15:0] a, input logic [15:0] c);
    mode_i[ch*2 +: 2]      = md;
    dir_i[ch]              = dr;
    addr_dec_i[ch]         = dec;
    autoinit_i[ch]         = ai;
    base_addr_i[ch*16 +: 16]  = a;
    base_count_i[ch*16 +: 16] = c;
    load_i[ch] = 1'b1;
    tick();
    load_i[ch] = 1'b0;
  endtask

  task automatic set_mask(input logic [3:0] v);
    mask_data_i = v;
    mask_wr_i = 1'b1;
    tick();
    mask_wr_i = 1'b0;
  endtask

  task automatic clr();
    bytes = 0;
    hrq_falls = 0;
  endtask

  initial begin
    run(3);
    rst_ni = 1'b1;
    tick();
    // R1 reset state
    cmp("R1 hrq", int'(hrq_o), 0);
    cmp("R1 dack", int'(dack_o), 0);
    cmp("R1 strobes", int'({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}), 0);
    cmp("R1 mask", int'(mask_o), 4'hF);

    // R7 block mode: request dropped early, count 2 -> 3 bytes
    setup(1, 2'b10, 0, 0, 0, 16'h1000, 16'd2);
    set_mask(4'b0000);
    clr();
    dreq_i[1] = 1'b1;
    run(3);
    dreq_i[1] = 1'b0;
    wait_idle();
    cmp("R7 bytes", bytes, 3);
    cmp("R7 hrq releases", hrq_falls, 1);
    cmp("R9 mask set at tc", int'(mask_o[1]), 1);

    // R6 demand mode, I/O to memory, decrementing; request removed after 2 bytes
    setup(2, 2'b00, 1, 1, 0, 16'h2005, 16'd9);
    clr();
    dreq_i[2] = 1'b1;
    wait_bytes(2);
    dreq_i[2] = 1'b0;
    wait_idle();
    cmp("R6 bytes", bytes, 2);
    cmp("R6 mask untouched", int'(mask_o[2]), 0);

    // R8/R9 single mode with auto-reload and ready stretching
    setup(3, 2'b01, 0, 0, 1, 16'h3000, 16'd1);
    clr();
    dreq_i[3] = 1'b1;
    for (int i = 0; i < 3000 && bytes < 3; i++) begin
      ready_i = (i % 3) != 0;
      tick();
    end
    dreq_i[3] = 1'b0;
    ready_i = 1'b1;
    wait_idle();
    cmp("R8 bytes", bytes, 3);
    cmp("R8 hrq drops per byte", hrq_falls, 3);
    cmp("R9 autoinit keeps mask", int'(mask_o[3]), 0);

    // R3 priority: ch0 and ch2 together, ch0 first
    setup(0, 2'b10, 0, 0, 0, 16'h0400, 16'd0);
    setup(2, 2'b10, 0, 0, 0, 16'h0800, 16'd0);
    set_mask(4'b0000);
    clr();
    arm = 1;
    dreq_i = 4'b0101;
    run(2);
    dreq_i[0] = 1'b0;
    wait_bytes(2);
    dreq_i = 4'b0000;
    wait_idle();
    cmp("R3 lowest first", int'(first_dack), 4'b0001);
    cmp("R3 both served", bytes, 2);

    // R3 masked channel ignored
    setup(0, 2'b10, 0, 0, 0, 16'h0410, 16'd0);
    setup(1, 2'b10, 0, 0, 0, 16'h0500, 16'd0);
    set_mask(4'b0001);
    clr();
    arm = 1;
    dreq_i = 4'b0011;
    run(2);
    dreq_i = 4'b0000;
    wait_idle();
    cmp("R3 masked skipped", int'(first_dack), 4'b0010);
    cmp("R3 masked bytes", bytes, 1);
    cmp("R3 masked bit kept", int'(mask_o[0]), 1);

    // R10 polarity
    dreq_low_i = 1'b1;
    dack_low_i = 1'b1;
    dreq_i = 4'b1111;
    tick();
    cmp("R10 idle dack level", int'(dack_o), 4'hF);
    setup(1, 2'b10, 0, 0, 0, 16'h0600, 16'd1);
    set_mask(4'b1101);
    clr();
    arm = 1;
    dreq_i = 4'b1101;
    run(2);
    dreq_i = 4'b1111;
    wait_idle();
    cmp("R10 active-low dack", int'(first_dack), 4'b1101);
    cmp("R10 bytes", bytes, 2);
    dreq_low_i = 1'b0;
    dack_low_i = 1'b0;
    dreq_i = 4'b0000;
    tick();

    // R11 disable
    enable_i = 1'b0;
    setup(2, 2'b10, 0, 0, 0, 16'h0700, 16'd0);
    set_mask(4'b1011);
    clr();
    dreq_i[2] = 1'b1;
    begin
      bit seen = 0;
      for (int i = 0; i < 20; i++) begin
        tick();
        if (hrq_o) seen = 1;
      end
      cmp("R11 no hrq while disabled", int'(seen), 0);
    end
    enable_i = 1'b1;
    run(2);
    dreq_i[2] = 1'b0;
    wait_idle();
    cmp("R11 served after enable", bytes, 1);

    // R2 slow grant: single mode must wait for grant to fall
    lag = 3;
    setup(1, 2'b01, 1, 0, 0, 16'h0900, 16'd1);
    set_mask(4'b1101);
    clr();
    dreq_i[1] = 1'b1;
    wait_bytes(2);
    dreq_i[1] = 1'b0;
    wait_idle();
    cmp("R2 bytes with lag", bytes, 2);
    cmp("R2 handshakes with lag", hrq_falls, 2);
    lag = 1;
    run(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule